// File: doc/BRIEF.md
# Dual Clock Halt Supervisor

This block keeps watch over two externally generated oscillator clocks: a fast main clock and a slow sub clock. It runs on a free-running internal reference clock. Each monitored clock flips a toggle flop in its own domain. That level is carried into the reference domain through a two-stage synchroniser, and every change seen there counts as proof of life. A per-clock counter measures how many reference cycles pass without such a change. When the count reaches that clock's timeout, a sticky halt flag is raised.

Software reaches the block through a single 8-bit control/status word on a simple synchronous bus: one write strobe, write data, and combinational read data. The word holds the two halt flags, an enable for the reference oscillator, one monitor enable per clock, and an enable for reset generation. When reset generation is enabled and software asks to move from main-clock mode to sub-clock mode while the sub clock is known to be halted, the block emits a one-cycle reset request. Monitoring stays idle after power-on until a strobe reports that the main oscillator's stabilisation wait has ended.

Top module: `clk_halt_supervisor`

## Requirements
- R1: After a power-on reset (`por` high at a `ref_clk` edge), `reg_rdata` reads 0x1C: reference enable (bit 4) = 1, main monitor enable (bit 3) = 1, sub monitor enable (bit 2) = 1, reset-request enable (bit 1) = 0, both halt flags (bit 6 main, bit 5 sub) = 0. `rst_req` = 0 and `ref_osc_en` = 1.
- R2: Bits 7 and 0 of `reg_rdata` always read 0, and writing 1 to them changes nothing.
- R3: The halt flags at bits 6 and 5 can only be set by hardware. A write with those bits at 1 leaves them unchanged.
- R4: No halt flag is raised before `stab_done` has been seen since the last power-on reset, even if a clock is stopped.
- R5: Once armed, with monitoring enabled, a main clock that stops for more than MAIN_TIMEOUT reference cycles (plus synchroniser delay) sets bit 6. A main clock that keeps running never sets it.
- R6: Once armed, with monitoring enabled, a sub clock that stops for more than SUB_TIMEOUT reference cycles (plus synchroniser delay) sets bit 5.
- R7: A halt flag stays set after its clock restarts and through `sys_rst`. Only a power-on reset clears it.
- R8: A clock whose monitor enable is 0 never gets its halt flag set.
- R9: `sys_rst` clears only the reset-request enable. It never sets a monitor enable. Only a power-on reset returns the monitor enables to 1.
- R10: A one-cycle `sub_mode_req` strobe while bit 1 = 1 and bit 5 = 1 makes `rst_req` high for exactly the next cycle. If bit 1 = 0 or bit 5 = 0, no pulse is produced.
- R11: A write that clears bit 4 takes effect only if both halt flags and both monitor enables are already 0. Otherwise bit 4 stays 1. `ref_osc_en` follows bit 4, and no halt is detected while bit 4 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running internal reference clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | Non-power-on system reset, synchronous, active high |
| main_clk | input | 1 | Monitored fast main oscillator clock |
| sub_clk | input | 1 | Monitored slow sub oscillator clock |
| stab_done | input | 1 | Strobe marking the end of the main-clock stabilisation wait |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| sub_mode_req | input | 1 | One-cycle strobe: software switches to sub-clock mode |
| rst_req | output | 1 | One-cycle system reset request |
| ref_osc_en | output | 1 | Enable for the reference oscillator |

## Verification
The bench builds the block with MAIN_TIMEOUT = 8 and SUB_TIMEOUT = 16. The main clock toggles every 10 ns and the sub clock every 30 ns, so both stay well inside their windows while running, and a stop of 40 reference cycles clearly exceeds either window plus the synchroniser delay. The shortened sub timeout keeps each halt episode short. That leaves room to cover, within one run, the full order of enables, stabilisation arming, sticky flags, both reset-request outcomes and the guarded clearing of the reference enable.

// File: rtl/chs_pkg.sv
package chs_pkg;

    localparam int REG_W       = 8;
    localparam int NUM_CLK     = 2;
    localparam int IDX_MAIN    = 0;
    localparam int IDX_SUB     = 1;

    // Field positions inside the control/status word
    localparam int B_MAIN_HALT = 6;
    localparam int B_SUB_HALT  = 5;
    localparam int B_REF_EN    = 4;
    localparam int B_MAIN_MON  = 3;
    localparam int B_SUB_MON   = 2;
    localparam int B_RST_EN    = 1;

    typedef struct packed {
        logic [NUM_CLK-1:0] halt;
        logic               ref_en;
        logic [NUM_CLK-1:0] mon_en;
        logic               rst_en;
    } csr_t;

    function automatic logic [REG_W-1:0] csr_pack(input csr_t c);
        logic [REG_W-1:0] r;
        r              = '0;
        r[B_MAIN_HALT] = c.halt[IDX_MAIN];
        r[B_SUB_HALT]  = c.halt[IDX_SUB];
        r[B_REF_EN]    = c.ref_en;
        r[B_MAIN_MON]  = c.mon_en[IDX_MAIN];
        r[B_SUB_MON]   = c.mon_en[IDX_SUB];
        r[B_RST_EN]    = c.rst_en;
        return r;
    endfunction

    function automatic logic [NUM_CLK-1:0] wr_mon(input logic [REG_W-1:0] d);
        logic [NUM_CLK-1:0] m;
        m[IDX_MAIN] = d[B_MAIN_MON];
        m[IDX_SUB]  = d[B_SUB_MON];
        return m;
    endfunction

    function automatic logic ref_clear_ok(input csr_t c);
        return (c.halt == '0) && (c.mon_en == '0);
    endfunction

endpackage

// File: rtl/chs_edge_sync.sv
module chs_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic mon_clk,
    input  logic ref_clk,
    input  logic por,
    output logic live
);
    logic               tgl_q;
    logic [SYNC_STAGES:0] shf_q;

    // Toggle flop in the monitored domain
    always_ff @(posedge mon_clk) begin
        if (por) tgl_q <= 1'b0;
        else     tgl_q <= ~tgl_q;
    end

    // Synchroniser plus one history stage in the reference domain
    always_ff @(posedge ref_clk) begin
        if (por) shf_q <= '0;
        else     shf_q <= {shf_q[SYNC_STAGES-1:0], tgl_q};
    end

    assign live = shf_q[SYNC_STAGES] ^ shf_q[SYNC_STAGES-1];

endmodule

// File: rtl/chs_halt_timer.sv
module chs_halt_timer #(
    parameter int TIMEOUT = 8
) (
    input  logic clk,
    input  logic por,
    input  logic active,
    input  logic live,
    output logic expired
);
    localparam int            CW    = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (por || !active)      cnt_q <= '0;
        else if (live)           cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = active && (cnt_q == LIMIT);

endmodule

// File: rtl/chs_ctrl_reg.sv
module chs_ctrl_reg
    import chs_pkg::*;
(
    input  logic               clk,
    input  logic               por,
    input  logic               sys_rst,
    input  logic               we,
    input  logic [REG_W-1:0]   wdata,
    input  logic [NUM_CLK-1:0] expired,
    input  logic               stab_done,
    input  logic               sub_mode_req,
    output csr_t               csr,
    output logic [NUM_CLK-1:0] active,
    output logic               rst_req
);
    csr_t csr_q;
    logic armed_q;
    logic rst_req_q;

    always_ff @(posedge clk) begin
        if (por) begin
            csr_q.halt   <= '0;
            csr_q.ref_en <= 1'b1;
            csr_q.mon_en <= '1;
            csr_q.rst_en <= 1'b0;
            armed_q      <= 1'b0;
            rst_req_q    <= 1'b0;
        end else begin
            csr_q.halt <= csr_q.halt | (expired & active);
            if (stab_done) armed_q <= 1'b1;
            rst_req_q <= sub_mode_req & csr_q.rst_en & csr_q.halt[IDX_SUB];
            if (sys_rst) begin
                csr_q.rst_en <= 1'b0;
            end else if (we) begin
                csr_q.rst_en <= wdata[B_RST_EN];
                csr_q.mon_en <= wr_mon(wdata);
                if (wdata[B_REF_EN] || ref_clear_ok(csr_q))
                    csr_q.ref_en <= wdata[B_REF_EN];
            end
        end
    end

    assign active  = {NUM_CLK{armed_q & csr_q.ref_en}} & csr_q.mon_en;
    assign csr     = csr_q;
    assign rst_req = rst_req_q;

endmodule

// File: rtl/clk_halt_supervisor.sv
module clk_halt_supervisor
    import chs_pkg::*;
#(
    parameter int MAIN_TIMEOUT = 8,
    parameter int SUB_TIMEOUT  = 64,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             ref_clk,
    input  logic             por,
    input  logic             sys_rst,
    input  logic             main_clk,
    input  logic             sub_clk,
    input  logic             stab_done,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sub_mode_req,
    output logic             rst_req,
    output logic             ref_osc_en
);
    logic [NUM_CLK-1:0] mon_clks;
    logic [NUM_CLK-1:0] live;
    logic [NUM_CLK-1:0] expired;
    logic [NUM_CLK-1:0] active;
    csr_t               csr;

    assign mon_clks[IDX_MAIN] = main_clk;
    assign mon_clks[IDX_SUB]  = sub_clk;

    for (genvar i = 0; i < NUM_CLK; i++) begin : g_mon
        localparam int TO = (i == IDX_MAIN) ? MAIN_TIMEOUT : SUB_TIMEOUT;

        chs_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .mon_clk (mon_clks[i]),
            .ref_clk (ref_clk),
            .por     (por),
            .live    (live[i])
        );

        chs_halt_timer #(.TIMEOUT(TO)) u_timer (
            .clk     (ref_clk),
            .por     (por),
            .active  (active[i]),
            .live    (live[i]),
            .expired (expired[i])
        );
    end

    chs_ctrl_reg u_ctrl (
        .clk          (ref_clk),
        .por          (por),
        .sys_rst      (sys_rst),
        .we           (reg_we),
        .wdata        (reg_wdata),
        .expired      (expired),
        .stab_done    (stab_done),
        .sub_mode_req (sub_mode_req),
        .csr          (csr),
        .active       (active),
        .rst_req      (rst_req)
    );

    assign reg_rdata  = csr_pack(csr);
    assign ref_osc_en = csr.ref_en;

endmodule

// File: rtl/chs_checker.sv
module chs_checker (
    input logic       ref_clk,
    input logic       por,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       sub_mode_req,
    input logic       rst_req,
    input logic       ref_osc_en
);
    p_main_sticky_r7: assert property (@(posedge ref_clk) disable iff (por)
        reg_rdata[6] |=> reg_rdata[6]);

    p_sub_sticky_r7: assert property (@(posedge ref_clk) disable iff (por)
        reg_rdata[5] |=> reg_rdata[5]);

    p_req_cause_r10: assert property (@(posedge ref_clk) disable iff (por)
        rst_req |-> $past(sub_mode_req && reg_rdata[5] && reg_rdata[1]));

    p_req_off_r10: assert property (@(posedge ref_clk) disable iff (por)
        (sub_mode_req && !reg_rdata[1]) |=> !rst_req);

    p_ref_clear_r11: assert property (@(posedge ref_clk) disable iff (por)
        $fell(ref_osc_en) |-> $past(reg_rdata[6:5] == 2'b00 && reg_rdata[3:2] == 2'b00));

    p_mon_set_r9: assert property (@(posedge ref_clk) disable iff (por)
        $rose(reg_rdata[3]) |-> $past(reg_we && reg_wdata[3]));

    p_flag_enable_r8: assert property (@(posedge ref_clk) disable iff (por)
        $rose(reg_rdata[6]) |-> $past(reg_rdata[3] && reg_rdata[4]));

endmodule

bind clk_halt_supervisor chs_checker u_chk (
    .ref_clk      (ref_clk),
    .por          (por),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .sub_mode_req (sub_mode_req),
    .rst_req      (rst_req),
    .ref_osc_en   (ref_osc_en)
);

// File: tb/tb_clk_halt_supervisor.sv
module tb_clk_halt_supervisor;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       sys_rst = 1'b0;
    logic       main_clk = 1'b0;
    logic       sub_clk = 1'b0;
    logic       main_run = 1'b1;
    logic       sub_run = 1'b1;
    logic       stab_done = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sub_mode_req = 1'b0;
    logic       rst_req;
    logic       ref_osc_en;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    typedef struct {
        logic [7:0] rd;
        logic       rq;
        logic       ro;
        string      tag;
    } item_t;

    item_t exp_q[$];

    always #4 clk = ~clk;
    always begin #10; if (main_run) main_clk = ~main_clk; end
    always begin #30; if (sub_run)  sub_clk  = ~sub_clk;  end

    clk_halt_supervisor #(.MAIN_TIMEOUT(8), .SUB_TIMEOUT(16)) dut (
        .ref_clk      (clk),
        .por          (por),
        .sys_rst      (sys_rst),
        .main_clk     (main_clk),
        .sub_clk      (sub_clk),
        .stab_done    (stab_done),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .sub_mode_req (sub_mode_req),
        .rst_req      (rst_req),
        .ref_osc_en   (ref_osc_en)
    );

    // Monitor: compare against the scoreboard away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            n_cmp++;
            if (reg_rdata !== it.rd || rst_req !== it.rq || ref_osc_en !== it.ro) begin
                n_bad++;
                $display("FAIL %s: got rdata=%02h rst_req=%b ref_osc_en=%b, expected rdata=%02h rst_req=%b ref_osc_en=%b",
                         it.tag, reg_rdata, rst_req, ref_osc_en, it.rd, it.rq, it.ro);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_state(input logic [7:0] rd, input logic rq, input logic ro, input string tag);
        item_t it;
        it.rd = rd; it.rq = rq; it.ro = ro; it.tag = tag;
        exp_q.push_back(it);
        tick(1);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_we = 1'b1; reg_wdata = d;
        tick(1);
        reg_we = 1'b0;
    endtask

    task automatic do_por();
        por = 1'b1;
        tick(5);
        por = 1'b0;
    endtask

    task automatic pulse_stab();
        stab_done = 1'b1; tick(1); stab_done = 1'b0;
    endtask

    task automatic pulse_mode();
        sub_mode_req = 1'b1; tick(1); sub_mode_req = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        tick(1);
        do_por();
        expect_state(8'h1C, 1'b0, 1'b1, "R1 reset value");

        // R2 / R3: reserved and flag bits ignore writes
        wr(8'hFF);
        expect_state(8'h1E, 1'b0, 1'b1, "R2 reserved bits read 0");
        expect_state(8'h1E, 1'b0, 1'b1, "R3 halt flags not writable");
        wr(8'h1C);

        // R4: not armed yet, stopped main clock is not flagged
        main_run = 1'b0; tick(40);
        expect_state(8'h1C, 1'b0, 1'b1, "R4 no detection before stabilisation");
        main_run = 1'b1; tick(10);

        pulse_stab();
        tick(40);
        expect_state(8'h1C, 1'b0, 1'b1, "R5 running clocks raise no flag");

        // R10: sub clock alive, no reset request
        wr(8'h1E);
        pulse_mode();
        expect_state(8'h1E, 1'b0, 1'b1, "R10 no request while sub clock alive");

        // R8: main monitor disabled
        wr(8'h16);
        main_run = 1'b0; tick(40);
        expect_state(8'h16, 1'b0, 1'b1, "R8 disabled monitor raises no flag");
        main_run = 1'b1; tick(10);
        wr(8'h1E);
        tick(10);

        // R5 main halt, R7 sticky
        main_run = 1'b0; tick(30);
        expect_state(8'h5E, 1'b0, 1'b1, "R5 main halt detected");
        main_run = 1'b1; tick(20);
        expect_state(8'h5E, 1'b0, 1'b1, "R7 main flag sticky after restart");

        // R6 sub halt
        sub_run = 1'b0; tick(40);
        expect_state(8'h7E, 1'b0, 1'b1, "R6 sub halt detected");

        // R10 reset request pulse
        pulse_mode();
        expect_state(8'h7E, 1'b1, 1'b1, "R10 request pulse");
        expect_state(8'h7E, 1'b0, 1'b1, "R10 pulse lasts one cycle");

        wr(8'h1C);
        pulse_mode();
        expect_state(8'h7C, 1'b0, 1'b1, "R10 no request when disabled");

        // R9 system reset clears reset enable only
        wr(8'h16);
        expect_state(8'h76, 1'b0, 1'b1, "R9 setup");
        sys_rst = 1'b1; tick(1); sys_rst = 1'b0;
        expect_state(8'h74, 1'b0, 1'b1, "R9 sys_rst clears only reset enable");
        expect_state(8'h74, 1'b0, 1'b1, "R7 flags survive sys_rst");

        // R11 clear refused while flags set
        wr(8'h00);
        expect_state(8'h70, 1'b0, 1'b1, "R11 clear refused while flags set");

        sub_run = 1'b1; tick(5);
        do_por();
        expect_state(8'h1C, 1'b0, 1'b1, "R9 power-on restores monitor enables");

        // R11 guarded clearing sequence
        wr(8'h0C);
        expect_state(8'h1C, 1'b0, 1'b1, "R11 clear refused while monitoring");
        wr(8'h00);
        expect_state(8'h10, 1'b0, 1'b1, "R11 monitors off, reference kept");
        wr(8'h00);
        expect_state(8'h00, 1'b0, 1'b0, "R11 reference cleared");
        pulse_stab();
        wr(8'h0C);
        main_run = 1'b0; tick(40);
        expect_state(8'h0C, 1'b0, 1'b0, "R11 no detection with reference off");
        main_run = 1'b1;

        tick(3);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            summary();
            $finish;
        end
    end

endmodule